// File: doc/BRIEF.md
# Program/Data Memory Access Router

This block sits between a small 8-bit microcontroller core and its memories. The core issues one request at a time. Each request has a space select (program or data), a direction, a 16-bit address and write data. The block decides which target serves the request: on-chip ROM, on-chip RAM or the external bus. It drives the three active-low external strobes, one for program fetch, one for data read and one for data write, and returns an acknowledge with read data.

Program space is read-only. A program fetch below the on-chip ROM size goes to ROM when the external-fetch pin is high. When the pin is low, every program fetch goes to the bus, and a fetch at or above the ROM size always goes to the bus. In data space, a configurable address window can be mapped onto on-chip RAM. A second configuration bit makes a mapped access still run a full external strobe cycle, while the data itself comes from, or goes to, the on-chip RAM.

The core holds a request until it is acknowledged. Configuration and pin values are sampled in the cycle the request is accepted.

Top module: `xmem_router`

## Requirements
- R1: While reset is asserted and after reset, with no request, `psenN`, `rdN` and `wrN` are high and `reqAck`, `romEn`, `ramEn` and `ramWe` are low.
- R2: A program read that goes to the bus drives `psenN` low for exactly 3 cycles. `reqAck` is high in the third of them and `reqRdata` equals `busRdata`. A program read goes to the bus when `forceExtCodeN` is 0 or when the address is 0x0800 or higher.
- R3: A program read below 0x0800 with `forceExtCodeN` = 1 is served by ROM. `romEn` is high for one cycle, `reqAck` is high in the cycle after acceptance, `reqRdata` equals `romRdata`, and all strobes stay high.
- R4: A data read routed to the bus drives `rdN` low for exactly 3 cycles. `busAddr` holds the request address and stays stable throughout, `reqAck` is high in the third cycle, and `reqRdata` equals `busRdata`.
- R5: A data write routed to the bus drives `wrN` low for exactly 3 cycles. `busAddr` and `busWdata` carry the request, `busDataOe` is high, and `reqAck` is high in the third cycle.
- R6: A program-space write is rejected. `reqAck` and `reqErr` are high in the cycle after acceptance, no strobe toggles, and neither ROM nor RAM is enabled.
- R7: With `cfgRamMapEn` = 1 and `cfgShadowEn` = 0, a data access at 0x2000 to 0x23FF is served by on-chip RAM in one cycle with no strobe. `ramAddr` is the address minus 0x2000. A read returns `ramRdata`, and a write pulses `ramWe` once with `ramWdata`.
- R8: With `cfgRamMapEn` = 0, data accesses inside the window go to the bus exactly like any other data address.
- R9: With `cfgRamMapEn` = 1 and `cfgShadowEn` = 1, a window access runs the 3-cycle `rdN`/`wrN` strobe on the bus while the data comes from, or goes to, on-chip RAM. `ramWe` pulses once, in the acknowledge cycle.
- R10: At most one of `psenN`, `rdN`, `wrN` is low in any cycle, and all are high in the cycle after an acknowledge.
- R11: `reqAck` is a single-cycle pulse for each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request pending, held until acknowledged |
| reqData | input | 1 | 1 = data space, 0 = program space |
| reqWrite | input | 1 | 1 = write |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| reqAck | output | 1 | Request complete (one-cycle pulse) |
| reqErr | output | 1 | Request rejected (program-space write), valid with ack |
| reqRdata | output | 8 | Read data, valid with ack |
| forceExtCodeN | input | 1 | 0 = all program fetches go external |
| cfgRamMapEn | input | 1 | Map the data window onto on-chip RAM |
| cfgShadowEn | input | 1 | Run the bus strobe cycle for mapped accesses too |
| psenN | output | 1 | Program fetch strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| busAddr | output | 16 | External address |
| busWdata | output | 8 | External write data |
| busDataOe | output | 1 | External data drive enable |
| busRdata | input | 8 | External read data |
| romEn | output | 1 | On-chip ROM read enable |
| romAddr | output | 11 | On-chip ROM address |
| romRdata | input | 8 | On-chip ROM data |
| ramEn | output | 1 | On-chip RAM enable |
| ramWe | output | 1 | On-chip RAM write pulse |
| ramAddr | output | 10 | On-chip RAM address (offset into window) |
| ramWdata | output | 8 | On-chip RAM write data |
| ramRdata | input | 8 | On-chip RAM read data |

## Verification
The hardest case to reach is a shadowed write. It needs both configuration bits set and an address inside the window, and it must show a full 3-cycle `wrN` strobe together with exactly one RAM write pulse. The window and ROM edges (0x07FF/0x0800, 0x1FFF/0x2000, 0x23FF/0x2400) are equally narrow. The stimulus therefore re-draws the pin and both configuration bits for every random request and biases addresses toward these edges. Directed requests then hit each edge and the shadowed read and write explicitly.

// File: rtl/xmem_router_pkg.sv
package xmem_router_pkg;

  typedef enum logic [2:0] {
    TGT_REJECT,
    TGT_ROM,
    TGT_RAM,
    TGT_BUS,
    TGT_SHADOW
  } target_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // capture request address/data
    logic selRom;    // ROM is the data source/target
    logic selRam;    // RAM is the data source/target
    logic selBus;    // external cycle in progress
    logic ramWrite;  // one RAM write pulse
    logic busWrite;  // drive external data
  } dpCtl_t;

endpackage

// File: rtl/xmem_router_ctrl.sv
module xmem_router_ctrl
  import xmem_router_pkg::*;
#(
  parameter int ROM_BYTES  = 2048,
  parameter int RAM_BASE   = 'h2000,
  parameter int RAM_BYTES  = 1024,
  parameter int BUS_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqData,
  input  logic        reqWrite,
  input  logic [15:0] reqAddr,
  input  logic        forceExtCodeN,
  input  logic        cfgRamMapEn,
  input  logic        cfgShadowEn,
  output logic        reqAck,
  output logic        reqErr,
  output logic        psenN,
  output logic        rdN,
  output logic        wrN,
  output dpCtl_t      dpCtl
);

  localparam int CNT_W = (BUS_CYCLES > 2) ? $clog2(BUS_CYCLES) : 1;
  localparam logic [16:0] ROM_LIM = 17'(ROM_BYTES);
  localparam logic [16:0] WIN_LO  = 17'(RAM_BASE);
  localparam logic [16:0] WIN_HI  = 17'(RAM_BASE + RAM_BYTES);
  localparam logic [CNT_W-1:0] EXT_LAST = CNT_W'(BUS_CYCLES - 1);

  logic [16:0]      addrX;
  logic             inRom;
  logic             inWin;
  target_e          nextTgt;
  logic             accept;

  logic             active;
  logic [CNT_W-1:0] cnt;
  target_e          tgt;
  logic             isData;
  logic             isWrite;

  logic             last;
  logic             busCyc;

  assign addrX = {1'b0, reqAddr};
  assign inRom = addrX < ROM_LIM;
  assign inWin = (addrX >= WIN_LO) && (addrX < WIN_HI);

  // target decode for the incoming request
  always_comb begin
    if (!reqData) begin
      if (reqWrite)                    nextTgt = TGT_REJECT;
      else if (forceExtCodeN && inRom) nextTgt = TGT_ROM;
      else                             nextTgt = TGT_BUS;
    end else if (cfgRamMapEn && inWin) begin
      nextTgt = cfgShadowEn ? TGT_SHADOW : TGT_RAM;
    end else begin
      nextTgt = TGT_BUS;
    end
  end

  assign accept = reqValid && !active;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      cnt     <= '0;
      tgt     <= TGT_REJECT;
      isData  <= 1'b0;
      isWrite <= 1'b0;
    end else if (accept) begin
      active  <= 1'b1;
      tgt     <= nextTgt;
      isData  <= reqData;
      isWrite <= reqWrite;
      cnt     <= (nextTgt == TGT_BUS || nextTgt == TGT_SHADOW) ? EXT_LAST : '0;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign last   = active && (cnt == '0);
  assign busCyc = active && (tgt == TGT_BUS || tgt == TGT_SHADOW);

  assign psenN  = !(busCyc && !isData);
  assign rdN    = !(busCyc && isData && !isWrite);
  assign wrN    = !(busCyc && isData && isWrite);

  assign reqAck = last;
  assign reqErr = last && (tgt == TGT_REJECT);

  always_comb begin
    dpCtl          = '0;
    dpCtl.load     = accept;
    dpCtl.selRom   = active && (tgt == TGT_ROM);
    dpCtl.selRam   = active && (tgt == TGT_RAM || tgt == TGT_SHADOW);
    dpCtl.selBus   = busCyc;
    dpCtl.ramWrite = dpCtl.selRam && isWrite && last;
    dpCtl.busWrite = busCyc && isData && isWrite;
  end

endmodule

// File: rtl/xmem_router_dp.sv
module xmem_router_dp
  import xmem_router_pkg::*;
#(
  parameter int ROM_AW   = 11,
  parameter int RAM_AW   = 10,
  parameter int RAM_BASE = 'h2000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [15:0]       reqAddr,
  input  logic [7:0]        reqWdata,
  output logic [7:0]        reqRdata,
  output logic [15:0]       busAddr,
  output logic [7:0]        busWdata,
  output logic              busDataOe,
  input  logic [7:0]        busRdata,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  localparam logic [15:0] WIN_BASE = 16'(RAM_BASE);

  logic [15:0] addrQ;
  logic [7:0]  wdataQ;
  logic [15:0] winOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (dpCtl.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  assign winOff    = addrQ - WIN_BASE;

  assign busAddr   = addrQ;
  assign busWdata  = wdataQ;
  assign busDataOe = dpCtl.busWrite;

  assign romEn     = dpCtl.selRom;
  assign romAddr   = addrQ[ROM_AW-1:0];

  assign ramEn     = dpCtl.selRam;
  assign ramWe     = dpCtl.ramWrite;
  assign ramAddr   = winOff[RAM_AW-1:0];
  assign ramWdata  = wdataQ;

  always_comb begin
    if (dpCtl.selRom)      reqRdata = romRdata;
    else if (dpCtl.selRam) reqRdata = ramRdata;
    else                   reqRdata = busRdata;
  end

endmodule

// File: rtl/xmem_router.sv
module xmem_router
  import xmem_router_pkg::*;
#(
  parameter int ROM_BYTES  = 2048,
  parameter int RAM_BASE   = 'h2000,
  parameter int RAM_BYTES  = 1024,
  parameter int BUS_CYCLES = 3,
  localparam int ROM_AW    = $clog2(ROM_BYTES),
  localparam int RAM_AW    = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqData,
  input  logic              reqWrite,
  input  logic [15:0]       reqAddr,
  input  logic [7:0]        reqWdata,
  output logic              reqAck,
  output logic              reqErr,
  output logic [7:0]        reqRdata,
  input  logic              forceExtCodeN,
  input  logic              cfgRamMapEn,
  input  logic              cfgShadowEn,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic [15:0]       busAddr,
  output logic [7:0]        busWdata,
  output logic              busDataOe,
  input  logic [7:0]        busRdata,
  output logic              romEn,
  output logic [ROM_AW-1:0] romAddr,
  input  logic [7:0]        romRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);

  dpCtl_t dpCtl;

  xmem_router_ctrl #(
    .ROM_BYTES (ROM_BYTES),
    .RAM_BASE  (RAM_BASE),
    .RAM_BYTES (RAM_BYTES),
    .BUS_CYCLES(BUS_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqData      (reqData),
    .reqWrite     (reqWrite),
    .reqAddr      (reqAddr),
    .forceExtCodeN(forceExtCodeN),
    .cfgRamMapEn  (cfgRamMapEn),
    .cfgShadowEn  (cfgShadowEn),
    .reqAck       (reqAck),
    .reqErr       (reqErr),
    .psenN        (psenN),
    .rdN          (rdN),
    .wrN          (wrN),
    .dpCtl        (dpCtl)
  );

  xmem_router_dp #(
    .ROM_AW  (ROM_AW),
    .RAM_AW  (RAM_AW),
    .RAM_BASE(RAM_BASE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqRdata (reqRdata),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busDataOe(busDataOe),
    .busRdata (busRdata),
    .romEn    (romEn),
    .romAddr  (romAddr),
    .romRdata (romRdata),
    .ramEn    (ramEn),
    .ramWe    (ramWe),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .ramRdata (ramRdata)
  );

endmodule

// File: rtl/xmem_router_chk.sv
module xmem_router_chk (
  input logic        clk,
  input logic        rstN,
  input logic        psenN,
  input logic        rdN,
  input logic        wrN,
  input logic        reqAck,
  input logic        reqErr,
  input logic        romEn,
  input logic        ramEn,
  input logic        ramWe,
  input logic        busDataOe,
  input logic [15:0] busAddr
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({!psenN, !rdN, !wrN}) <= 1); // R10

  AST_IDLE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> (psenN && rdN && wrN)); // R10

  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck); // R11

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> (psenN && rdN && wrN && !romEn && !ramEn)); // R6

  AST_ROM_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    romEn |-> (psenN && rdN && wrN)); // R3

  AST_PSEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(psenN) |=> !psenN); // R2

  AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN && $past(!rdN)) |-> $stable(busAddr)); // R4

  AST_WR_DRIVES_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> busDataOe); // R5

  AST_RAMWE_AT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (reqAck && ramEn)); // R9

endmodule

bind xmem_router xmem_router_chk u_chk (.*);

// File: tb/tb_xmem_router.sv
`timescale 1ns/1ps
module tb_xmem_router;

  localparam int ROM_BYTES = 2048;
  localparam int WIN_BASE  = 'h2000;
  localparam int WIN_BYTES = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqData = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqAck, reqErr;
  logic [7:0]  reqRdata;
  logic        forceExtCodeN = 1'b1, cfgRamMapEn = 1'b0, cfgShadowEn = 1'b0;
  logic        psenN, rdN, wrN, busDataOe;
  logic [15:0] busAddr;
  logic [7:0]  busWdata, busRdata;
  logic        romEn, ramEn, ramWe;
  logic [10:0] romAddr;
  logic [9:0]  ramAddr;
  logic [7:0]  romRdata, ramRdata, ramWdata;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  assign romRdata = romAddr[7:0] ^ 8'h5A;
  assign ramRdata = ramAddr[7:0] + 8'h33;
  assign busRdata = busAddr[7:0] ^ busAddr[15:8] ^ 8'hC3;

  xmem_router dut (.*);

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // 0 reject, 1 rom, 2 ram, 3 bus, 4 shadow
  function automatic int kindOf(logic d, logic w, logic [15:0] a,
                                logic fx, logic mp, logic sh);
    bit win = (a >= WIN_BASE) && (a < WIN_BASE + WIN_BYTES);
    if (!d) begin
      if (w) return 0;
      if (fx && a < ROM_BYTES) return 1;
      return 3;
    end
    if (mp && win) return sh ? 4 : 2;
    return 3;
  endfunction

  function automatic string tagOf(int k, logic d, logic w, logic [15:0] a, logic mp);
    bit win = (a >= WIN_BASE) && (a < WIN_BASE + WIN_BYTES);
    case (k)
      0: return "R6";
      1: return "R3";
      2: return "R7";
      4: return "R9";
      default: begin
        if (!d) return "R2";
        if (win && !mp) return "R8";
        return w ? "R5" : "R4";
      end
    endcase
  endfunction

  task automatic doReq(input logic d, input logic w, input logic [15:0] a,
                       input logic [7:0] wd);
    int k = kindOf(d, w, a, forceExtCodeN, cfgRamMapEn, cfgShadowEn);
    string tag = tagOf(k, d, w, a, cfgRamMapEn);
    int cyc = 0, psC = 0, rdC = 0, wrC = 0, multiC = 0;
    int romC = 0, ramC = 0, weC = 0, busBad = 0;
    bit ackSeen = 0;
    logic [7:0] gotRd = '0, weData = '0;
    logic [9:0] weAddr = '0;
    logic gotErr = 0;
    bit ext = (k == 3 || k == 4);
    logic [15:0] off = a - 16'(WIN_BASE);
    logic [7:0] expRd;

    @(negedge clk);
    reqValid = 1; reqData = d; reqWrite = w; reqAddr = a; reqWdata = wd;
    for (int i = 0; i < 10 && !ackSeen; i++) begin
      @(negedge clk);
      cyc++;
      if (!psenN) psC++;
      if (!rdN) rdC++;
      if (!wrN) begin
        wrC++;
        if (busAddr !== a || busWdata !== wd || !busDataOe) busBad++;
      end
      if (!rdN && busAddr !== a) busBad++;
      if (((!psenN) + (!rdN) + (!wrN)) > 1) multiC++;
      if (romEn) romC++;
      if (ramEn) ramC++;
      if (ramWe) begin weC++; weAddr = ramAddr; weData = ramWdata; end
      if (reqAck) begin ackSeen = 1; gotRd = reqRdata; gotErr = reqErr; end
    end
    reqValid = 0;
    @(negedge clk);
    chk("R10", "strobes high after ack", {psenN, rdN, wrN}, 3'b111);
    chk("R11", "ack single pulse", reqAck, 0);

    chk(tag, "latency", cyc, ext ? 3 : 1);
    chk(tag, "reject flag", gotErr, (k == 0));
    chk(tag, "psen cycles", psC, (ext && !d) ? 3 : 0);
    chk(tag, "rd cycles", rdC, (ext && d && !w) ? 3 : 0);
    chk(tag, "wr cycles", wrC, (ext && d && w) ? 3 : 0);
    chk(tag, "rom enable cycles", romC, (k == 1) ? 1 : 0);
    chk(tag, "ram enable cycles", ramC, (k == 2) ? 1 : (k == 4) ? 3 : 0);
    chk(tag, "ram write pulses", weC, ((k == 2 || k == 4) && w) ? 1 : 0);
    chk("R10", "overlapping strobes", multiC, 0);
    if (ext) chk(tag, "bus address/data", busBad, 0);
    if (!w && k != 0) begin
      case (k)
        1:       expRd = a[7:0] ^ 8'h5A;
        2, 4:    expRd = off[7:0] + 8'h33;
        default: expRd = a[7:0] ^ a[15:8] ^ 8'hC3;
      endcase
      chk(tag, "read data", gotRd, expRd);
    end
    if (w && weC == 1) begin
      chk(tag, "ram write address", weAddr, off[9:0]);
      chk(tag, "ram write data", weData, wd);
    end
  endtask

  function automatic logic [15:0] pickAddr();
    case ($urandom_range(0, 5))
      0: return 16'($urandom_range(0, ROM_BYTES - 1));
      1: return 16'(ROM_BYTES - 2 + $urandom_range(0, 3));
      2: return 16'(WIN_BASE + $urandom_range(0, WIN_BYTES - 1));
      3: return 16'(WIN_BASE - 2 + $urandom_range(0, 3));
      4: return 16'(WIN_BASE + WIN_BYTES - 2 + $urandom_range(0, 3));
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin : watchdog
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin : main
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2005);
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", {psenN, rdN, wrN}, 3'b111);
    chk("R1", "enables in reset", {reqAck, romEn, ramEn, ramWe}, 4'b0);
    rstN = 1;
    repeat (2) @(negedge clk);
    chk("R1", "strobes idle", {psenN, rdN, wrN}, 3'b111);
    chk("R1", "enables idle", {reqAck, romEn, ramEn, ramWe}, 4'b0);

    // directed corners
    forceExtCodeN = 1; cfgRamMapEn = 0; cfgShadowEn = 0;
    doReq(0, 0, 16'h07FF, 8'h00);   // R3 last ROM byte
    doReq(0, 0, 16'h0800, 8'h00);   // R2 first external code byte
    doReq(0, 1, 16'h0010, 8'hAA);   // R6 program write
    forceExtCodeN = 0;
    doReq(0, 0, 16'h0000, 8'h00);   // R2 pin forces external
    doReq(1, 0, 16'h2000, 8'h00);   // R8 window unmapped
    doReq(1, 1, 16'h23FF, 8'h5C);   // R8 write, unmapped
    cfgRamMapEn = 1;
    doReq(1, 0, 16'h2000, 8'h00);   // R7 window base
    doReq(1, 1, 16'h23FF, 8'h77);   // R7 window top write
    doReq(1, 0, 16'h1FFF, 8'h00);   // R4 just below window
    doReq(1, 1, 16'h2400, 8'h19);   // R5 just above window
    cfgShadowEn = 1;
    doReq(1, 0, 16'h2123, 8'h00);   // R9 shadow read
    doReq(1, 1, 16'h2345, 8'hE1);   // R9 shadow write

    for (int n = 0; n < 400; n++) begin
      logic d, w;
      forceExtCodeN = 1'($urandom());
      cfgRamMapEn   = 1'($urandom());
      cfgShadowEn   = 1'($urandom());
      d = 1'($urandom());
      w = d ? 1'($urandom()) : ($urandom_range(0, 3) == 0);
      doReq(d, w, pickAddr(), 8'($urandom()));
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule